// File: doc/BRIEF.md
# Program Load and Result Dump Sequencer

This block is the sequencer that sits around a small execution core. It owns two memories: a 256-entry program store with 14-bit words and a 256-entry result store with 8-bit bytes. It gives the core one read port into the program store and one read/write port into the result store. The core itself, which decodes and executes instructions, lives outside this block.

When reset is released, the block walks through the whole result store and writes zero to one entry per clock. Only after that does it raise `done_o`. While it is idle, holding the load strobe streams instruction words into the program store at consecutive addresses starting from zero. A start pulse hands control to the core, and the core keeps running until it reports a halt. The block then raises `valid_o`. A result request streams result bytes 0x00 to 0x0F to the byte output, one per clock. When the last byte has gone out, the block drops `valid_o` and raises `done_o`.

Top module: `cpu_shell_top`

## Requirements
- R1: After `rst_ni` is released, `done_o` stays low for 256 rising edges and is high from the 256th edge on. By then every result byte reads as 0x00.
- R2: `start_i` and `load_en_i` have no effect while the reset sweep is running. `core_run_o` stays low, and no program word is written.
- R3: While idle, each rising edge with `load_en_i` high writes `load_word_i` into the program store at the address one above the previous write.
- R4: A rising edge where `load_en_i` is high after being low in the previous cycle writes to program address 0x00.
- R5: In idle (with `done_o` high), `start_i` makes `core_run_o` rise and `done_o` fall on the next edge. `core_run_o` holds until `core_halt_i` is sampled high. On that edge `core_run_o` falls and `valid_o` rises.
- R6: `core_pdata_o` combinationally shows the program word at `core_paddr_i`. While `core_run_o` is high, an edge with `core_rwe_i` writes `core_rwdata_i` to result address `core_raddr_i`, and `core_rdata_o` shows the byte at that address.
- R7: With `valid_o` high and no dump running, a sampled `dump_req_i` starts a dump. For the next 16 cycles `dout_o` shows result bytes 0x00 to 0x0F in ascending order, one per cycle. `dout_o` is 0x00 whenever no dump is running.
- R8: On the edge that ends the 16th dump cycle, `valid_o` falls and `done_o` rises together.
- R9: `dump_req_i` is ignored while the core is running, and `start_i` is ignored while the core is running or halted. `valid_o` and `done_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Program load strobe |
| load_word_i | input | 14 | Instruction word to store |
| start_i | input | 1 | Start execution request |
| dump_req_i | input | 1 | Result output request |
| core_halt_i | input | 1 | Core reports halt |
| core_run_o | output | 1 | Core may execute |
| core_paddr_i | input | 8 | Core program read address |
| core_pdata_o | output | 14 | Program word at core address |
| core_raddr_i | input | 8 | Core result address |
| core_rwe_i | input | 1 | Core result write enable |
| core_rwdata_i | input | 8 | Core result write data |
| core_rdata_o | output | 8 | Result byte at core address |
| valid_o | output | 1 | Results ready or being sent |
| done_o | output | 1 | Sweep or dump finished |
| dout_o | output | 8 | Dumped result byte |

## Verification
The dump is tried with three result patterns: an all-zero store straight after the sweep, a full 16-byte ramp written by a stub core, and a partial overwrite that touches only the even addresses. Together they separate a correct ascending walk from a stuck, reversed or offset address, and they show whether old contents survive between runs. The core also writes outside the window, which shows that the dump does not stray past 0x0F. A second reset followed by a zero dump shows that the sweep really clears earlier data. Program loading is tried with one continuous burst and then a short second burst, which tells address continuation apart from the restart at zero.

// File: rtl/cpu_shell_pkg.sv
package cpu_shell_pkg;
  typedef enum logic [2:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_RUN,
    ST_HALT,
    ST_DUMP
  } shell_state_e;
endpackage

// File: rtl/shell_ram.sv
module shell_ram #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int Depth = 1 << AW;

  logic [W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/shell_loader.sv
module shell_loader #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic          load_ok_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o
);
  logic          prev_q;
  logic [AW-1:0] next_q;

  // fresh strobe restarts at zero
  assign addr_o = (load_en_i && !prev_q) ? '0 : next_q;
  assign we_o   = load_en_i && load_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      next_q <= '0;
    end else begin
      prev_q <= load_en_i;
      if (we_o) next_q <= addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/shell_fsm.sv
module shell_fsm
  import cpu_shell_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DUMP_N = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic          dump_req_i,
  output shell_state_e  state_o,
  output logic [AW-1:0] cnt_o,
  output logic          valid_o,
  output logic          done_o
);
  localparam logic [AW-1:0] SweepLast = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] DumpLast  = AW'(DUMP_N - 1);

  shell_state_e  state_q;
  logic [AW-1:0] cnt_q;
  logic          valid_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SWEEP;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SWEEP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SweepLast) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          done_q  <= 1'b0;
        end
        ST_RUN: if (halt_i) begin
          state_q <= ST_HALT;
          valid_q <= 1'b1;
        end
        ST_HALT: if (dump_req_i) begin
          state_q <= ST_DUMP;
          cnt_q   <= '0;
        end
        ST_DUMP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DumpLast) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
endmodule

// File: rtl/cpu_shell_top.sv
module cpu_shell_top
  import cpu_shell_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PW     = 14,
  parameter int DW     = 8,
  parameter int DUMP_N = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic [PW-1:0] load_word_i,
  input  logic          start_i,
  input  logic          dump_req_i,
  input  logic          core_halt_i,
  output logic          core_run_o,
  input  logic [AW-1:0] core_paddr_i,
  output logic [PW-1:0] core_pdata_o,
  input  logic [AW-1:0] core_raddr_i,
  input  logic          core_rwe_i,
  input  logic [DW-1:0] core_rwdata_i,
  output logic [DW-1:0] core_rdata_o,
  output logic          valid_o,
  output logic          done_o,
  output logic [DW-1:0] dout_o
);
  shell_state_e  state;
  logic [AW-1:0] cnt;
  logic          pm_we;
  logic [AW-1:0] pm_addr;
  logic          rm_we;
  logic [AW-1:0] rm_waddr, rm_raddr;
  logic [DW-1:0] rm_wdata, rm_rdata;
  logic          sweeping, dumping;

  shell_fsm #(.AW(AW), .DUMP_N(DUMP_N)) u_fsm (
    .clk_i, .rst_ni, .start_i, .halt_i(core_halt_i), .dump_req_i,
    .state_o(state), .cnt_o(cnt), .valid_o, .done_o
  );

  shell_loader #(.AW(AW)) u_load (
    .clk_i, .rst_ni, .load_en_i, .load_ok_i(state == ST_IDLE),
    .we_o(pm_we), .addr_o(pm_addr)
  );

  shell_ram #(.AW(AW), .W(PW)) u_pmem (
    .clk_i, .we_i(pm_we), .waddr_i(pm_addr), .wdata_i(load_word_i),
    .raddr_i(core_paddr_i), .rdata_o(core_pdata_o)
  );

  assign sweeping   = state == ST_SWEEP;
  assign dumping    = state == ST_DUMP;
  assign core_run_o = state == ST_RUN;

  assign rm_we    = sweeping || (core_run_o && core_rwe_i);
  assign rm_waddr = sweeping ? cnt : core_raddr_i;
  assign rm_wdata = sweeping ? '0 : core_rwdata_i;
  assign rm_raddr = dumping ? cnt : core_raddr_i;

  shell_ram #(.AW(AW), .W(DW)) u_rmem (
    .clk_i, .we_i(rm_we), .waddr_i(rm_waddr), .wdata_i(rm_wdata),
    .raddr_i(rm_raddr), .rdata_o(rm_rdata)
  );

  assign core_rdata_o = rm_rdata;
  assign dout_o       = dumping ? rm_rdata : '0;
endmodule

// File: rtl/cpu_shell_chk.sv
module cpu_shell_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_en_i,
  input logic          start_i,
  input logic          core_halt_i,
  input logic          core_run_o,
  input logic          valid_o,
  input logic          done_o,
  input logic [DW-1:0] dout_o,
  input logic          pm_we,
  input logic [AW-1:0] pm_addr
);
  assert_load_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we && $past(pm_we) |-> pm_addr == AW'($past(pm_addr) + 1));

  assert_load_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we && !$past(load_en_i) |-> pm_addr == '0);

  assert_start_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_run_o) |-> $past(start_i) && $past(done_o) && !done_o);

  assert_halt_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_run_o && core_halt_i |=> valid_o && !core_run_o);

  assert_dout_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_o != '0 |-> valid_o);

  assert_done_after_dump_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && $past(valid_o) |-> !valid_o);

  assert_flags_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && valid_o));
endmodule

bind cpu_shell_top cpu_shell_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en_i), .start_i(start_i),
  .core_halt_i(core_halt_i), .core_run_o(core_run_o), .valid_o(valid_o),
  .done_o(done_o), .dout_o(dout_o), .pm_we(pm_we), .pm_addr(pm_addr)
);

// File: tb/cpu_shell_top_tb_top.sv
`timescale 1ns/1ps
module cpu_shell_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [13:0] load_word = '0;
  logic        start = 1'b0;
  logic        dump_req = 1'b0;
  logic        halt = 1'b0;
  logic        run;
  logic [7:0]  paddr = '0;
  logic [13:0] pdata;
  logic [7:0]  raddr = '0;
  logic        rwe = 1'b0;
  logic [7:0]  rwdata = '0;
  logic [7:0]  rdata;
  logic        valid, done;
  logic [7:0]  dout;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  cpu_shell_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_word_i(load_word),
    .start_i(start), .dump_req_i(dump_req), .core_halt_i(halt), .core_run_o(run),
    .core_paddr_i(paddr), .core_pdata_o(pdata), .core_raddr_i(raddr),
    .core_rwe_i(rwe), .core_rwdata_i(rwdata), .core_rdata_o(rdata),
    .valid_o(valid), .done_o(done), .dout_o(dout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_sweep();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    // R2: load and start held during the sweep
    start = 1'b1; load_en = 1'b1; load_word = 14'h1abc;
    repeat (20) @(negedge clk);
    check("R1 done low at 20", {31'd0, done}, 32'd0);
    check("R2 run during sweep", {31'd0, run}, 32'd0);
    check("R1 valid low", {31'd0, valid}, 32'd0);
    check("R7 dout zero", {24'd0, dout}, 32'd0);
    start = 1'b0; load_en = 1'b0;
    repeat (235) @(negedge clk);
    check("R1 done low at 255", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R1 done high at 256", {31'd0, done}, 32'd1);
    check("R2 run stays low", {31'd0, run}, 32'd0);
    paddr = 8'h00; #1;
    n_chk++;
    if (pdata === 14'h1abc) begin
      n_bad++;
      $display("FAIL R2: actual %h expected not 1abc", pdata);
    end
  endtask

  function automatic logic [13:0] wfun(input int i);
    return 14'(14'h2000 + i * 37);
  endfunction

  task automatic t_load();
    @(negedge clk);
    load_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      load_word = wfun(i);
      @(negedge clk);
    end
    load_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      paddr = 8'(i); #1;
      check("R3 load seq", {18'd0, pdata}, {18'd0, wfun(i)});
    end
    @(negedge clk);
    load_en = 1'b1;
    load_word = 14'h0111; @(negedge clk);
    load_word = 14'h0222; @(negedge clk);
    load_en = 1'b0;
    paddr = 8'h00; #1; check("R4 restart addr0", {18'd0, pdata}, 32'h0111);
    paddr = 8'h01; #1; check("R4 restart addr1", {18'd0, pdata}, 32'h0222);
    paddr = 8'h02; #1; check("R4 addr2 kept", {18'd0, pdata}, {18'd0, wfun(2)});
  endtask

  // mode 0: no writes, 1: full ramp, 2: even addresses only
  task automatic t_run(input int mode);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 run high", {31'd0, run}, 32'd1);
    check("R5 done fell", {31'd0, done}, 32'd0);
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    check("R9 dump ignored in run valid", {31'd0, valid}, 32'd0);
    check("R9 dump ignored in run dout", {24'd0, dout}, 32'd0);
    if (mode != 0) begin
      for (int k = 0; k < 16; k++) begin
        if (mode == 1 || (k % 2) == 0) begin
          raddr = 8'(k); rwdata = (mode == 1) ? 8'(8'ha0 ^ (k * 7)) : 8'(8'h30 + k);
          rwe = 1'b1;
          model[k] = rwdata;
          @(negedge clk);
        end
      end
      raddr = 8'h20; rwdata = 8'h55; @(negedge clk);
      rwe = 1'b0;
      raddr = 8'h03; #1;
      check("R6 core readback", {24'd0, rdata}, {24'd0, model[3]});
    end
    check("R5 still running", {31'd0, run}, 32'd1);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check("R5 run fell", {31'd0, run}, 32'd0);
    check("R5 valid rose", {31'd0, valid}, 32'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 start ignored in halt", {31'd0, run}, 32'd0);
  endtask

  task automatic t_dump();
    @(negedge clk);
    check("R7 dout idle zero", {24'd0, dout}, 32'd0);
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    for (int k = 0; k < 16; k++) begin
      check($sformatf("R7 byte %0d", k), {24'd0, dout}, {24'd0, model[k]});
      check("R9 flags excl", {30'd0, valid, done}, 32'd2);
      @(negedge clk);
    end
    check("R8 valid fell", {31'd0, valid}, 32'd0);
    check("R8 done rose", {31'd0, done}, 32'd1);
    check("R7 dout back to zero", {24'd0, dout}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_sweep();
    t_load();
    t_run(0);
    t_dump();   // R1: cleared store
    t_run(1);
    t_dump();
    t_run(2);
    t_dump();
    t_sweep();
    t_run(0);
    t_dump();   // R1: second sweep clears old data
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule